// File: doc/BRIEF.md
# Minute Rounding Time Adjuster

This block keeps a seconds/minutes/hours time of day in BCD, advanced by an eight-stage binary sub-second prescaler that divides a 256 Hz tick enable. A host reaches the three time fields and a control register through a small register port. Setting the control bit starts a correction that rounds the time to the nearest whole minute. Seconds of 30 or more go to zero and carry one into the minutes, with the normal carry into hours. Seconds of 29 or fewer simply go to zero.

The correction is a multi-cycle operation of a fixed, parameterised length. While it runs, the control bit reads back as 1, the prescaler is held at zero, prescaler ticks are dropped, and host access to the time fields is refused. Writes to them are discarded and reads of them return zero. At the last cycle the rounding is applied and the prescaler is left cleared. The control bit then falls back to 0 without any action from the host.

Top module: `minute_round_adj`

## Requirements
- R1: After reset the seconds, minutes and hours fields read 0x00, the prescaler count is 0 and `adj_busy` is 0.
- R2: Each cycle with `tick_en` high advances the prescaler by one. When a tick arrives with the prescaler at all ones, it wraps to 0 and seconds advance in BCD. Seconds 0x59 wrap to 0x00 with a carry into minutes, minutes 0x59 wrap to 0x00 with a carry into hours, and hours 0x23 wrap to 0x00.
- R3: A write to address 3 with data bit 0 set, while idle, raises `adj_busy` at the next clock edge. It holds `adj_busy` and control read bit 0 at 1 for exactly ADJ_CYCLES cycles, after which both return to 0 on their own.
- R4: When a correction ends with seconds at 0x30 or above, seconds become 0x00 and minutes advance by one with normal carry: 0x59 minutes become 0x00 and the hour advances, and 23:59 becomes 00:00.
- R5: When a correction ends with seconds at 0x29 or below, seconds become 0x00 and minutes and hours are unchanged.
- R6: The prescaler is cleared at the edge that starts a correction and stays 0 for the whole correction, with ticks ignored. It reads 0 right after the correction and counts again from there.
- R7: While `adj_busy` is 1, writes to addresses 0 to 2 are discarded and reads of addresses 0 to 2 return 0x00.
- R8: Writing address 3 with bit 0 clear has no effect. Writing bit 0 set while a correction runs neither restarts nor lengthens it.
- R9: The register map is address 0 seconds (bits 6:0), address 1 minutes (bits 6:0), address 2 hours (bits 5:0, higher bits dropped on write), and address 3 control (bit 0 adjust/busy, other bits read 0). An idle write loads the addressed time field at the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_en | input | 1 | Sub-second tick enable (256 per second) |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address for read and write |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data for `addr` (combinational) |
| adj_busy | output | 1 | High while a minute-rounding correction runs |
| sub_count | output | SUB_BITS | Current sub-second prescaler count |

## Verification
The bench rounds at both sides of the 29/30 seconds threshold, and at 23:59:30, where the carry has to run through minutes and hours. A design that compared the wrong digit or skipped the carry would leave the minutes or hours wrong. It also writes a seconds field, ticks the prescaler and re-arms the adjust bit in the middle of a correction. A design that leaked host writes, kept counting or restarted the counter would show altered seconds, a non-zero prescaler or a busy window longer than ADJ_CYCLES. Prescaler and BCD rollovers at 0x09, 0x59 and 23:59:59 are driven with exact tick counts, so an off-by-one in the sub-second wrap shows up as a late or early seconds step.

// File: rtl/mra_pkg.sv
package mra_pkg;

  localparam int FIELD_W    = 7;
  localparam int NUM_FIELDS = 3;

  typedef logic [FIELD_W-1:0] bcd_t;

  typedef enum logic [1:0] {
    ADDR_SEC  = 2'd0,
    ADDR_MIN  = 2'd1,
    ADDR_HOUR = 2'd2,
    ADDR_CTRL = 2'd3
  } reg_addr_e;

  // Largest legal BCD value of a time field (0 sec, 1 min, 2 hour).
  function automatic bcd_t field_max(int idx);
    return (idx == 2) ? 7'h23 : 7'h59;
  endfunction

  // Bits kept when the host writes a field.
  function automatic bcd_t field_mask(int idx);
    return (idx == 2) ? 7'h3f : 7'h7f;
  endfunction

  // One BCD step with wrap to zero at the field limit.
  function automatic bcd_t bcd_step(bcd_t v, bcd_t maxv);
    bcd_t r;
    if (v == maxv) begin
      r = '0;
    end else if (v[3:0] >= 4'd9) begin
      r = {v[6:4] + 3'd1, 4'd0};
    end else begin
      r = {v[6:4], v[3:0] + 4'd1};
    end
    return r;
  endfunction

endpackage

// File: rtl/mra_rst_sync.sv
module mra_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic stage1_q;
  logic stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign rst_sync_n = stage2_q;

endmodule

// File: rtl/mra_prescaler.sv
module mra_prescaler #(
  parameter int SUB_BITS = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick_en,
  input  logic                clr,
  output logic [SUB_BITS-1:0] count,
  output logic                carry
);

  logic [SUB_BITS-1:0] cnt_q;
  logic [SUB_BITS-1:0] cnt_d;
  logic                cnt_en;

  // Clear has priority; a tick during clear is dropped.
  assign cnt_en = clr | tick_en;

  always_comb begin
    cnt_d = cnt_q;
    if (clr) begin
      cnt_d = '0;
    end else if (tick_en) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign carry = tick_en & ~clr & (&cnt_q);
  assign count = cnt_q;

endmodule

// File: rtl/mra_bcd_field.sv
module mra_bcd_field
  import mra_pkg::*;
#(
  parameter int IDX = 0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic inc,
  input  logic zero,
  input  logic load,
  input  bcd_t load_val,
  output bcd_t val,
  output logic wrap
);

  localparam bcd_t MAXV = field_max(IDX);

  bcd_t val_q;
  bcd_t val_d;
  logic val_en;

  assign val_en = load | zero | inc;

  always_comb begin
    val_d = val_q;
    if (load) begin
      val_d = load_val;
    end else if (zero) begin
      val_d = '0;
    end else if (inc) begin
      val_d = bcd_step(val_q, MAXV);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val_q <= '0;
    end else if (val_en) begin
      val_q <= val_d;
    end
  end

  assign val  = val_q;
  assign wrap = inc & ~load & ~zero & (val_q == MAXV);

endmodule

// File: rtl/mra_adj_ctrl.sv
module mra_adj_ctrl #(
  parameter int ADJ_CYCLES = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ctrl_wr,
  input  logic ctrl_bit,
  output logic busy,
  output logic start,
  output logic done
);

  localparam int CW = (ADJ_CYCLES > 1) ? $clog2(ADJ_CYCLES) : 1;
  localparam logic [CW-1:0] LOAD_VAL = CW'(ADJ_CYCLES - 1);

  logic          busy_q;
  logic          busy_d;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          st_en;

  assign start = ctrl_wr & ctrl_bit & ~busy_q;
  assign done  = busy_q & (cnt_q == '0);
  assign st_en = start | busy_q;

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    if (start) begin
      busy_d = 1'b1;
      cnt_d  = LOAD_VAL;
    end else if (done) begin
      busy_d = 1'b0;
    end else if (busy_q) begin
      cnt_d  = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (st_en) begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
    end
  end

  assign busy = busy_q;

endmodule

// File: rtl/minute_round_adj.sv
module minute_round_adj
  import mra_pkg::*;
#(
  parameter int SUB_BITS   = 8,
  parameter int ADJ_CYCLES = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick_en,
  input  logic                wr_en,
  input  logic [1:0]          addr,
  input  logic [7:0]          wr_data,
  output logic [7:0]          rd_data,
  output logic                adj_busy,
  output logic [SUB_BITS-1:0] sub_count
);

  localparam bcd_t ROUND_LIMIT = 7'h30;

  logic                  rst_core_n;
  logic                  busy;
  logic                  adj_start;
  logic                  adj_done;
  logic                  pre_clr;
  logic                  sec_tick;
  logic                  round_inc;
  logic                  ctrl_wr;
  bcd_t                  field_val [NUM_FIELDS];
  logic [NUM_FIELDS-1:0] field_wrap;
  logic [NUM_FIELDS-1:0] field_inc;
  logic [NUM_FIELDS-1:0] field_load;
  logic [NUM_FIELDS-1:0] field_zero;
  bcd_t                  sec_q;
  logic                  unused_bits;

  mra_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_core_n)
  );

  assign ctrl_wr = wr_en & (addr == ADDR_CTRL);

  mra_adj_ctrl #(
    .ADJ_CYCLES (ADJ_CYCLES)
  ) u_adj_ctrl (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .ctrl_wr  (ctrl_wr),
    .ctrl_bit (wr_data[0]),
    .busy     (busy),
    .start    (adj_start),
    .done     (adj_done)
  );

  assign pre_clr = adj_start | busy;

  mra_prescaler #(
    .SUB_BITS (SUB_BITS)
  ) u_prescaler (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .tick_en (tick_en),
    .clr     (pre_clr),
    .count   (sub_count),
    .carry   (sec_tick)
  );

  assign sec_q     = field_val[0];
  assign round_inc = adj_done & (sec_q >= ROUND_LIMIT);

  for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_field
    if (g == 0) begin : g_sec
      assign field_inc[g]  = sec_tick;
      assign field_zero[g] = adj_done;
    end else if (g == 1) begin : g_min
      assign field_inc[g]  = field_wrap[g-1] | round_inc;
      assign field_zero[g] = 1'b0;
    end else begin : g_upper
      assign field_inc[g]  = field_wrap[g-1];
      assign field_zero[g] = 1'b0;
    end

    assign field_load[g] = wr_en & ~busy & (addr == 2'(g));

    mra_bcd_field #(
      .IDX (g)
    ) u_field (
      .clk      (clk),
      .rst_n    (rst_core_n),
      .inc      (field_inc[g]),
      .zero     (field_zero[g]),
      .load     (field_load[g]),
      .load_val (wr_data[FIELD_W-1:0] & field_mask(g)),
      .val      (field_val[g]),
      .wrap     (field_wrap[g])
    );
  end

  always_comb begin
    rd_data = 8'h00;
    case (addr)
      ADDR_SEC:  rd_data = busy ? 8'h00 : {1'b0, field_val[0]};
      ADDR_MIN:  rd_data = busy ? 8'h00 : {1'b0, field_val[1]};
      ADDR_HOUR: rd_data = busy ? 8'h00 : {1'b0, field_val[2]};
      default:   rd_data = {7'd0, busy};
    endcase
  end

  assign adj_busy    = busy;
  assign unused_bits = field_wrap[NUM_FIELDS-1] ^ wr_data[7];

endmodule

// File: rtl/minute_round_adj_chk.sv
module minute_round_adj_chk #(
  parameter int SUB_BITS   = 8,
  parameter int ADJ_CYCLES = 3
) (
  input logic                clk,
  input logic                rst_n,
  input logic                adj_busy,
  input logic                wr_en,
  input logic [1:0]          addr,
  input logic [7:0]          wr_data,
  input logic [7:0]          rd_data,
  input logic [SUB_BITS-1:0] sub_count,
  input logic [6:0]          sec_q
);

  int busy_len_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_len_q <= 0;
    end else if (adj_busy) begin
      busy_len_q <= busy_len_q + 1;
    end else begin
      busy_len_q <= 0;
    end
  end

  assert_busy_from_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(adj_busy) |-> $past(wr_en && addr == 2'd3 && wr_data[0]));

  assert_busy_not_long_R3: assert property (@(posedge clk) disable iff (!rst_n)
    adj_busy |-> busy_len_q < ADJ_CYCLES);

  assert_busy_full_len_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(adj_busy) |-> busy_len_q == ADJ_CYCLES);

  assert_prescaler_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
    adj_busy |-> sub_count == '0);

  assert_prescaler_left_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(adj_busy) |-> sub_count == '0);

  assert_reads_blocked_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (adj_busy && addr != 2'd3) |-> rd_data == 8'h00);

  assert_seconds_zeroed_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(adj_busy) |-> sec_q == 7'h00);

endmodule

bind minute_round_adj minute_round_adj_chk #(
  .SUB_BITS   (SUB_BITS),
  .ADJ_CYCLES (ADJ_CYCLES)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .adj_busy  (adj_busy),
  .wr_en     (wr_en),
  .addr      (addr),
  .wr_data   (wr_data),
  .rd_data   (rd_data),
  .sub_count (sub_count),
  .sec_q     (sec_q)
);

// File: tb/minute_round_adj_tb.sv
`timescale 1ns/10ps
module minute_round_adj_tb;

  localparam int SUB_BITS = 8;
  localparam int ADJ      = 3;
  localparam int K_RD     = 0;
  localparam int K_BUSY   = 1;
  localparam int K_SUB    = 2;

  typedef struct {
    int         kind;
    logic [7:0] exp;
    string      tag;
  } exp_t;

  logic                clk;
  logic                rst_n;
  logic                tick_en;
  logic                wr_en;
  logic [1:0]          addr;
  logic [7:0]          wr_data;
  logic [7:0]          rd_data;
  logic                adj_busy;
  logic [SUB_BITS-1:0] sub_count;

  int   total;
  int   bad;
  bit   finished;
  exp_t sbq[$];
  event sample_ev;

  minute_round_adj #(
    .SUB_BITS   (SUB_BITS),
    .ADJ_CYCLES (ADJ)
  ) u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_en   (tick_en),
    .wr_en     (wr_en),
    .addr      (addr),
    .wr_data   (wr_data),
    .rd_data   (rd_data),
    .adj_busy  (adj_busy),
    .sub_count (sub_count)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // Monitor: pops the expected item and compares it with the port.
  initial begin
    forever begin
      exp_t       it;
      logic [7:0] act;
      @(sample_ev);
      it = sbq.pop_front();
      case (it.kind)
        K_RD:    act = rd_data;
        K_BUSY:  act = {7'd0, adj_busy};
        default: act = 8'(sub_count);
      endcase
      total++;
      if (act !== it.exp) begin
        bad++;
        $display("FAIL %s: actual=0x%02h expected=0x%02h", it.tag, act, it.exp);
      end
    end
  end

  task automatic expect_item(int kind, logic [1:0] a, logic [7:0] exp, string tag);
    if (kind == K_RD) addr = a;
    #0.1;
    sbq.push_back('{kind, exp, tag});
    ->sample_ev;
    #0.1;
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic ticks(int n);
    @(negedge clk);
    tick_en = 1'b1;
    repeat (n) @(negedge clk);
    tick_en = 1'b0;
  endtask

  task automatic set_time(logic [7:0] h, logic [7:0] m, logic [7:0] s);
    wr(2'd2, h);
    wr(2'd1, m);
    wr(2'd0, s);
  endtask

  task automatic check_time(logic [7:0] h, logic [7:0] m, logic [7:0] s, string tag);
    expect_item(K_RD, 2'd0, s, {tag, " sec"});
    expect_item(K_RD, 2'd1, m, {tag, " min"});
    expect_item(K_RD, 2'd2, h, {tag, " hour"});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    total = 0; bad = 0; finished = 1'b0;
    rst_n = 1'b0; tick_en = 1'b0; wr_en = 1'b0; addr = 2'd0; wr_data = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check_time(8'h00, 8'h00, 8'h00, "R1 reset");
    expect_item(K_BUSY, 2'd0, 8'h00, "R1 busy");
    expect_item(K_SUB, 2'd0, 8'h00, "R1 prescaler");

    // R9 register loads and hour mask
    set_time(8'h05, 8'h34, 8'h12);
    check_time(8'h05, 8'h34, 8'h12, "R9 load");
    wr(2'd2, 8'h7f);
    expect_item(K_RD, 2'd2, 8'h3f, "R9 hour mask");
    expect_item(K_RD, 2'd3, 8'h00, "R9 ctrl idle");
    wr(2'd2, 8'h05);

    // R2 prescaler and seconds step
    ticks(10);
    expect_item(K_SUB, 2'd0, 8'd10, "R2 prescaler count");
    expect_item(K_RD, 2'd0, 8'h12, "R2 no early step");
    ticks(246);
    expect_item(K_SUB, 2'd0, 8'd0, "R2 prescaler wrap");
    expect_item(K_RD, 2'd0, 8'h13, "R2 sec step");

    // R2 digit carry
    wr(2'd0, 8'h09);
    ticks(256);
    expect_item(K_RD, 2'd0, 8'h10, "R2 digit carry");

    // R2 full rollover
    set_time(8'h23, 8'h59, 8'h59);
    ticks(256);
    check_time(8'h00, 8'h00, 8'h00, "R2 day rollover");

    // R5 round down, with R3/R6/R7/R8 during the run
    set_time(8'h01, 8'h10, 8'h29);
    ticks(5);
    expect_item(K_SUB, 2'd0, 8'd5, "R6 pre-count");
    wr(2'd3, 8'h01);
    expect_item(K_BUSY, 2'd0, 8'h01, "R3 busy raised");
    expect_item(K_RD, 2'd3, 8'h01, "R3 ctrl reads 1");
    expect_item(K_SUB, 2'd0, 8'h00, "R6 cleared at start");
    expect_item(K_RD, 2'd0, 8'h00, "R7 sec read blocked");
    wr_en = 1'b1; addr = 2'd0; wr_data = 8'h44; tick_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b1; addr = 2'd3; wr_data = 8'h01;
    @(negedge clk);
    wr_en = 1'b0; tick_en = 1'b0;
    expect_item(K_BUSY, 2'd0, 8'h01, "R3 busy third cycle");
    expect_item(K_SUB, 2'd0, 8'h00, "R6 ticks ignored");
    @(negedge clk);
    expect_item(K_BUSY, 2'd0, 8'h00, "R3 busy self-cleared");
    expect_item(K_RD, 2'd3, 8'h00, "R3 ctrl reads 0");
    expect_item(K_SUB, 2'd0, 8'h00, "R6 prescaler left clear");
    check_time(8'h01, 8'h10, 8'h00, "R5 round down R7 write dropped");
    @(negedge clk);
    expect_item(K_BUSY, 2'd0, 8'h00, "R8 no restart");
    ticks(3);
    expect_item(K_SUB, 2'd0, 8'd3, "R6 counting resumes");

    // R4 round up through hours
    set_time(8'h23, 8'h59, 8'h30);
    wr(2'd3, 8'h01);
    repeat (2) @(negedge clk);
    expect_item(K_BUSY, 2'd0, 8'h01, "R3 still busy");
    @(negedge clk);
    expect_item(K_BUSY, 2'd0, 8'h00, "R3 done");
    check_time(8'h00, 8'h00, 8'h00, "R4 23:59:30");

    // R4 plain round up
    set_time(8'h12, 8'h07, 8'h45);
    wr(2'd3, 8'h81);
    repeat (3) @(negedge clk);
    check_time(8'h12, 8'h08, 8'h00, "R4 12:07:45");

    // R8 writes with bit 0 clear
    wr(2'd0, 8'h45);
    wr(2'd3, 8'h00);
    expect_item(K_BUSY, 2'd0, 8'h00, "R8 zero write no start");
    wr(2'd3, 8'hfe);
    expect_item(K_BUSY, 2'd0, 8'h00, "R8 bit0 clear no start");
    expect_item(K_RD, 2'd0, 8'h45, "R8 sec untouched");

    repeat (2) @(negedge clk);
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule